// File: doc/BRIEF.md
# Manchester Transmit Encoder

This block converts a serial NRZ bit stream into a Manchester line code. It runs from a reference clock at twice the bit rate (20 MHz for 10 Mb/s) and divides it by two to make the bit clock, which it exports so that the upstream controller can launch its data and enable against it. On each rising bit-clock edge the block captures the enable and the data bit. On the two falling reference edges that follow, it sends the two halves of the Manchester cell.

The line is modelled as a single logic level plus a separate drive flag. When the drive flag is low, the outputs stand for a zero-differential line. A static select picks one of two idle conditions. In the first, the line is held at a steady high level and the drive flag stays set. In the second, the drive flag is dropped, which models an undriven, zero-differential pair suited to transformer-coupled loads.

Top module: `manchester_tx_encoder`

## Requirements
- R1: `bit_clk` toggles on every rising edge of `clk_ref`, so its period is two reference periods with equal high and low times. It reads 0 while reset is held.
- R2: `tx_en` and `tx_data` are sampled only at the rising `clk_ref` edge where `bit_clk` goes from 0 to 1. Changes at any other time have no effect on the line.
- R3: In a cell captured with `tx_en`=1, `drive_on` is 1 for both halves. A data 1 gives `line_out`=0 in the first half and 1 in the second. A data 0 gives `line_out`=1 in the first half and 0 in the second.
- R4: The first half of a cell is launched on the falling `clk_ref` edge right after the capturing `bit_clk` rise, and the second half on the next falling `clk_ref` edge. Before that first falling edge, the line keeps its previous value.
- R5: Consecutive enabled cells follow each other with no gap and no extra half-bit.
- R6: A cell captured with `tx_en`=0 is idle in both halves. A cell whose first half has started is always finished, even if `tx_en` drops during it.
- R7: With `idle_zero`=0, idle is `line_out`=1 with `drive_on`=1.
- R8: With `idle_zero`=1, idle is `drive_on`=0 with `line_out`=0.
- R9: Asynchronous active-low `rst_n` forces the idle condition at once, abandons any partly sent cell and holds `bit_clk` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, sampled on rising `bit_clk` |
| tx_data | input | 1 | NRZ data bit, sampled on rising `bit_clk` |
| idle_zero | input | 1 | Static idle select: 0 steady high, 1 zero differential |
| bit_clk | output | 1 | Divided bit clock (reference / 2) |
| line_out | output | 1 | Encoded line level |
| drive_on | output | 1 | Line driven; 0 models zero differential |

## Verification
The bench decodes the line at each half-bit and compares every cell with the enable and data applied for it. A polarity swap would show up as inverted halves, and an off-by-one capture would shift the data by one cell. It probes the line just before and just after the launching falling edge, which exposes a half launched on the wrong reference edge. It also toggles the inputs between capture edges, which catches a design that samples continuously. Further checks cover an enable dropping mid-cell, both idle modes, and a reset in the middle of a cell; an encoder that truncated cells, confused the idle levels or left a stale half-bit after reset would fail them.

// File: rtl/mte_pkg.sv
package mte_pkg;
   typedef struct packed {
      logic en;
      logic data;
   } mte_cell_t;

   localparam int unsigned MTE_HALVES_PER_CELL = 2;
endpackage

// File: rtl/mte_clkdiv.sv
module mte_clkdiv #(
   parameter int unsigned RATIO = 2
) (
   input  logic clk_ref,
   input  logic rst_n,
   output logic bit_clk_q
);
   initial begin
      if (RATIO != 2) $error("mte_clkdiv: only a divide-by-two bit clock is supported");
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) bit_clk_q <= 1'b0;
      else        bit_clk_q <= ~bit_clk_q;
   end
endmodule

// File: rtl/mte_sampler.sv
module mte_sampler
   import mte_pkg::*;
(
   input  logic      clk_ref,
   input  logic      rst_n,
   input  logic      bit_clk_q,
   input  logic      tx_en,
   input  logic      tx_data,
   output mte_cell_t cell_q
);
   // bit_clk_q low before this edge means the bit clock rises here
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)          cell_q <= '0;
      else if (!bit_clk_q) cell_q <= '{en: tx_en, data: tx_data};
   end
endmodule

// File: rtl/mte_halfbit_drv.sv
module mte_halfbit_drv
   import mte_pkg::*;
#(
   parameter bit ZERO_IDLE_LEVEL = 1'b0
) (
   input  logic      clk_ref,
   input  logic      rst_n,
   input  logic      bit_clk_q,
   input  mte_cell_t cell_q,
   input  logic      idle_zero,
   output logic      line_out,
   output logic      drive_on
);
   logic active_q;
   logic level_q;
   logic second_q;
   logic idle_level;

   assign idle_level = idle_zero ? ZERO_IDLE_LEVEL : 1'b1;

   // falling reference edge: bit clock high -> first half, low -> second half
   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         level_q  <= 1'b0;
         second_q <= 1'b0;
      end else if (bit_clk_q) begin
         active_q <= cell_q.en;
         level_q  <= ~cell_q.data;
         second_q <= cell_q.en;
      end else begin
         active_q <= second_q;
         level_q  <= ~level_q;
         second_q <= 1'b0;
      end
   end

   assign line_out = active_q ? level_q : idle_level;
   assign drive_on = active_q | ~idle_zero;
endmodule

// File: rtl/manchester_tx_encoder.sv
module manchester_tx_encoder
   import mte_pkg::*;
#(
   parameter bit ZERO_IDLE_LEVEL = 1'b0
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_data,
   input  logic idle_zero,
   output logic bit_clk,
   output logic line_out,
   output logic drive_on
);
   localparam int unsigned DIV_RATIO = MTE_HALVES_PER_CELL;

   mte_cell_t cell_q;

   mte_clkdiv #(.RATIO(DIV_RATIO)) u_div (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .bit_clk_q (bit_clk)
   );

   mte_sampler u_smp (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .bit_clk_q (bit_clk),
      .tx_en     (tx_en),
      .tx_data   (tx_data),
      .cell_q    (cell_q)
   );

   mte_halfbit_drv #(.ZERO_IDLE_LEVEL(ZERO_IDLE_LEVEL)) u_drv (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .bit_clk_q (bit_clk),
      .cell_q    (cell_q),
      .idle_zero (idle_zero),
      .line_out  (line_out),
      .drive_on  (drive_on)
   );
endmodule

// File: rtl/mte_checker.sv
module mte_checker (
   input logic clk_ref,
   input logic rst_n,
   input logic tx_en,
   input logic tx_data,
   input logic idle_zero,
   input logic bit_clk,
   input logic line_out,
   input logic drive_on
);
   logic [1:0] armed_q;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)             armed_q <= 2'd0;
      else if (armed_q != 2'd3) armed_q <= armed_q + 2'd1;
   end

   assert_clk_toggles_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (armed_q != 2'd0) |-> (bit_clk != $past(bit_clk)));

   // first half of an enabled cell: inverse of the captured data (R2, R3, R4)
   assert_first_half_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (armed_q != 2'd0 && bit_clk && $past(tx_en)) |-> (drive_on && line_out == !$past(tx_data)));

   assert_second_half_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (armed_q == 2'd3 && !bit_clk && $past(bit_clk) && $past(tx_en, 2))
      |-> (drive_on && line_out == $past(tx_data, 2)));

   assert_idle_high_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (armed_q != 2'd0 && bit_clk && !$past(tx_en) && !idle_zero) |-> (drive_on && line_out));

   assert_idle_zero_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (armed_q != 2'd0 && bit_clk && !$past(tx_en) && idle_zero) |-> !drive_on);

   assert_reset_idle_R9: assert property (@(posedge clk_ref)
      !rst_n |-> (!bit_clk && (idle_zero ? !drive_on : (drive_on && line_out))));
endmodule

bind manchester_tx_encoder mte_checker u_chk (
   .clk_ref   (clk_ref),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .tx_data   (tx_data),
   .idle_zero (idle_zero),
   .bit_clk   (bit_clk),
   .line_out  (line_out),
   .drive_on  (drive_on)
);

// File: tb/manchester_tx_encoder_tb.sv
module manchester_tx_encoder_tb;
   logic clk_ref = 1'b0;
   logic rst_n;
   logic tx_en = 1'b0;
   logic tx_data = 1'b0;
   logic idle_zero = 1'b0;
   logic idle_next = 1'b0;
   logic bit_clk, line_out, drive_on;

   always #10 clk_ref = ~clk_ref;

   manchester_tx_encoder u_dut (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .tx_data   (tx_data),
      .idle_zero (idle_zero),
      .bit_clk   (bit_clk),
      .line_out  (line_out),
      .drive_on  (drive_on)
   );

   typedef struct {
      logic en;
      logic data;
      logic iz;
   } exp_t;

   exp_t exp_q[$];
   exp_t cur;
   int   checks = 0;
   int   fails  = 0;
   logic [1:0] h1;
   bit   have_h1 = 1'b0;

   task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, expv, $time);
      end
   endtask

   // monitor: decode each cell from its two half-bit samples, {drive_on,line_out}
   always @(posedge clk_ref) begin
      #1;
      if (rst_n !== 1'b1) begin
         have_h1 = 1'b0;
      end else if (!bit_clk) begin
         h1 = {drive_on, line_out};
         have_h1 = 1'b1;
      end else if (have_h1) begin
         have_h1 = 1'b0;
         if (exp_q.size() > 0) begin
            logic [3:0] e4;
            cur = exp_q.pop_front();
            if (cur.en)     e4 = {1'b1, ~cur.data, 1'b1, cur.data};
            else if (cur.iz) e4 = 4'b0000;
            else            e4 = 4'b1111;
            if (cur.en)
               check({h1, drive_on, line_out} == e4, "R3 R5 cell encoding", {h1, drive_on, line_out}, e4);
            else if (cur.iz)
               check({h1, drive_on, line_out} == e4, "R6 R8 zero idle cell", {h1, drive_on, line_out}, e4);
            else
               check({h1, drive_on, line_out} == e4, "R6 R7 high idle cell", {h1, drive_on, line_out}, e4);
         end
      end
   end

   task automatic send_bit(input logic en, input logic d, input bit glitch);
      tx_en   = en;
      tx_data = d;
      if (glitch) begin
         #10; tx_en = ~en; tx_data = ~d;
         #10; tx_en = en;  tx_data = d;
      end
      @(posedge bit_clk);
      #3;
      idle_zero = idle_next;
      exp_q.push_back('{en, d, idle_zero});
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] lf;
      logic prev;
      #1 rst_n = 1'b0;
      #40;
      check(bit_clk == 1'b0, "R9 bit clock held in reset", {3'b0, bit_clk}, 4'b0000);
      check({drive_on, line_out} == 2'b11, "R9 R7 idle during reset", {2'b0, drive_on, line_out}, 4'b0011);
      @(negedge clk_ref);
      rst_n = 1'b1;

      // R1: divide by two
      @(posedge clk_ref); #1 prev = bit_clk;
      for (int i = 0; i < 6; i++) begin
         @(posedge clk_ref); #1;
         check(bit_clk != prev, "R1 bit clock toggles each ref edge", {3'b0, bit_clk}, {3'b0, ~prev});
         prev = bit_clk;
      end

      // idle lead-in and alternating preamble-like frame
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 16; i++) send_bit(1'b1, (i % 2 == 0), 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);

      // pseudo-random frame
      lf = 8'hA5;
      for (int i = 0; i < 40; i++) begin
         send_bit(1'b1, lf[0], 1'b0);
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      end
      // R6: enable drops right after the last capture; the cell must complete
      send_bit(1'b0, 1'b1, 1'b0);

      // runs of ones and zeros
      for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);

      // R4: launch on the falling ref edge after the capture
      send_bit(1'b1, 1'b1, 1'b0);
      fork
         begin
            #4;
            check(line_out == 1'b1, "R4 line holds before launch edge", {3'b0, line_out}, 4'b0001);
            #5;
            check(line_out == 1'b0 && drive_on, "R4 first half after falling edge", {2'b0, drive_on, line_out}, 4'b0010);
            #20;
            check(line_out == 1'b1 && drive_on, "R4 second half after next falling edge", {2'b0, drive_on, line_out}, 4'b0011);
         end
      join_none
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);

      // R2: inputs toggled between capture edges
      for (int i = 0; i < 10; i++) send_bit(1'b1, (i % 3 == 0), 1'b1);
      send_bit(1'b0, 1'b0, 1'b1);
      send_bit(1'b0, 1'b0, 1'b0);

      // R8: zero-differential idle around a frame
      idle_next = 1'b1;
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) send_bit(1'b1, (i % 2 == 1), 1'b0);
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1, 1'b0);
      idle_next = 1'b0;
      for (int i = 0; i < 2; i++) send_bit(1'b0, 1'b0, 1'b0);

      // R9: reset in the middle of a cell
      send_bit(1'b1, 1'b1, 1'b0);
      tx_en = 1'b0;
      #10;
      rst_n = 1'b0;
      exp_q.delete();
      #1;
      check({drive_on, line_out} == 2'b11, "R9 idle forced at reset mid-cell", {2'b0, drive_on, line_out}, 4'b0011);
      check(bit_clk == 1'b0, "R9 bit clock cleared", {3'b0, bit_clk}, 4'b0000);
      repeat (3) @(posedge clk_ref);
      #1;
      check(bit_clk == 1'b0 && line_out == 1'b1, "R9 held idle in reset", {2'b0, bit_clk, line_out}, 4'b0001);
      @(negedge clk_ref);
      rst_n = 1'b1;
      @(posedge bit_clk); @(posedge bit_clk); #1;
      check({drive_on, line_out} == 2'b11, "R9 no stale half after reset", {2'b0, drive_on, line_out}, 4'b0011);
      for (int i = 0; i < 4; i++) send_bit(1'b1, (i < 2), 1'b0);
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, 1'b0);
      repeat (3) @(posedge bit_clk);
      #5;
      summary();
      $finish;
   end
endmodule